// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tagging

This block is the receive-side buffer of a 16550-class serial port. A deserializer hands it one character at a time with a push strobe and three per-character error flags: parity, framing and break. The block stores each character together with its flags. A character's flags appear in the line status byte only while that character is the oldest unread one. The CPU side has one read strobe and a one-bit register select. Select 0 addresses the receive buffer, and a read there removes the oldest character. Select 1 addresses the line status byte, and a read there acknowledges the error state.

Two buffering modes are supported. With the FIFO enabled the buffer holds up to `DEPTH` characters. With it disabled the buffer acts as a single holding register. The block is built so that same-cycle collisions never lose state. A status read in the same cycle as a push keeps the new character's flags. A buffer read in the same cycle as a push keeps data-ready asserted and never raises a false overrun. Leaving FIFO mode empties the buffer, and a separate clear input empties it on demand.

Top module: `rx_err_fifo`

## Requirements
- R1: `dr_o` is high exactly when at least one unread character is held. With `reg_sel_i`=0, `rd_data_o` shows the oldest character, or zero when the buffer is empty. A read (`rd_i`=1, `reg_sel_i`=0) removes the oldest character.
- R2: Each stored character carries its own parity, framing and break flags. The line status byte (`reg_sel_i`=1) is laid out as bit0 data ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, and bits 7..5 zero. Bits 2..4 show only the oldest character's flags.
- R3: A status read (`rd_i`=1, `reg_sel_i`=1) while the buffer is non-empty hides the oldest character's flags until that character is removed. The next character's flags then appear.
- R4: A status read in the same cycle that a character is pushed into an empty buffer does not hide or lose that character's flags or the interrupt they raise.
- R5: A push in the same cycle as a buffer read stores the new character and keeps `dr_o` high. It is not an overrun, in either mode, even when the buffer was full.
- R6: A push while the buffer is full and no buffer read happens in the same cycle sets overrun. The buffer is full at `DEPTH` characters in FIFO mode and at 1 character in holding mode. The incoming character is discarded and the stored ones are kept.
- R7: Overrun stays set until a status read. If a new overrun happens in the same cycle as a status read, overrun stays set.
- R8: `irq_o` is high whenever overrun is set or the oldest character has a flag that is not hidden.
- R9: When `fifo_en_i` goes from 1 to 0, the buffer is emptied. When `fifo_en_i` goes from 0 to 1, a character already in the holding register is kept.
- R10: `rx_clr_i` empties the buffer and wins over a push in the same cycle. It leaves the overrun flag unchanged.
- R11: After reset the buffer is empty, overrun and the interrupt are low, and `rd_data_o` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Character push strobe from the deserializer |
| push_data_i | input | DATA_W | Received character |
| push_perr_i | input | 1 | Parity error for the pushed character |
| push_ferr_i | input | 1 | Framing error for the pushed character |
| push_brk_i | input | 1 | Break detected for the pushed character |
| rd_i | input | 1 | CPU read strobe |
| reg_sel_i | input | 1 | 0 selects the receive buffer, 1 selects the line status byte |
| fifo_en_i | input | 1 | FIFO mode enable; 0 selects holding-register mode |
| rx_clr_i | input | 1 | Receive buffer clear pulse |
| rd_data_o | output | DATA_W | Read data for the selected register |
| dr_o | output | 1 | Data ready |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Receiver line status interrupt |

## Verification
The bench targets the same-cycle collisions. A design that checks the status-read acknowledge against the write slot would clear a character's flags as that character enters an empty buffer. A design that tests fullness before applying the same-cycle pop would report an overrun on a push-and-read in a full holding register or a full FIFO. A design that let a status read take priority over a new overrun would drop that overrun. The bench also toggles the mode, clears in the same cycle as a push, and fills to exactly `DEPTH` and one beyond. These catch stale data exposed after re-enabling, a clear that loses to a push, and an overrun that overwrites stored data instead of discarding the incoming character.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // line status bit positions (software decodes these)
  localparam int unsigned LSR_DR = 0;
  localparam int unsigned LSR_OE = 1;
  localparam int unsigned LSR_PE = 2;
  localparam int unsigned LSR_FE = 3;
  localparam int unsigned LSR_BI = 4;
  // flag field order inside a stored entry: {brk, ferr, perr}
  localparam int unsigned FLG_W  = 3;
  localparam int unsigned FLG_PE = 0;
  localparam int unsigned FLG_FE = 1;
  localparam int unsigned FLG_BI = 2;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned ENT_W = 11,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic             pop_i,
  input  logic [ENT_W-1:0] wdata_i,
  output logic [ENT_W-1:0] head_o,
  output logic [CW-1:0]    cnt_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i)  wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({wr_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic             lsr_rd_i,
  input  logic             ovr_evt_i,
  input  logic             nonempty_i,
  input  logic [FLG_W-1:0] head_flg_i,
  output logic [FLG_W-1:0] flg_o,
  output logic             ovr_o,
  output logic             irq_o
);
  logic ovr_q, hide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
    end else if (ovr_evt_i) begin
      ovr_q <= 1'b1;          // new overrun beats a same-cycle acknowledge
    end else if (lsr_rd_i) begin
      ovr_q <= 1'b0;
    end
  end

  // hide bit is tied to the current head; only set when a head exists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hide_q <= 1'b0;
    end else if (flush_i || pop_i) begin
      hide_q <= 1'b0;
    end else if (lsr_rd_i && nonempty_i) begin
      hide_q <= 1'b1;
    end
  end

  assign flg_o = (nonempty_i && !hide_q) ? head_flg_i : '0;
  assign ovr_o = ovr_q;
  assign irq_o = ovr_q | (|flg_o);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ENT_W = DATA_W + FLG_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_perr_i,
  input  logic              push_ferr_i,
  input  logic              push_brk_i,
  input  logic              rd_i,
  input  logic              reg_sel_i,
  input  logic              fifo_en_i,
  input  logic              rx_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dr_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic             en_q;
  logic             flush_w, pop_w, wr_w, ovr_evt_w, lsr_rd_w, full_w, nonempty_w;
  logic [CW-1:0]    cnt_w;
  logic [ENT_W-1:0] head_w, wdata_w;
  logic [FLG_W-1:0] push_flg_w, flg_w;
  logic [DATA_W-1:0] lsr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fifo_en_i;
  end

  assign flush_w    = rx_clr_i | (en_q & ~fifo_en_i);
  assign nonempty_w = (cnt_w != '0);
  assign full_w     = fifo_en_i ? (cnt_w == CW'(DEPTH)) : nonempty_w;
  assign pop_w      = rd_i & ~reg_sel_i & nonempty_w & ~flush_w;
  assign lsr_rd_w   = rd_i & reg_sel_i;
  // fullness is judged after the same-cycle pop
  assign ovr_evt_w  = push_i & ~flush_w & full_w & ~pop_w;
  assign wr_w       = push_i & ~flush_w & (~full_w | pop_w);

  always_comb begin
    push_flg_w         = '0;
    push_flg_w[FLG_PE] = push_perr_i;
    push_flg_w[FLG_FE] = push_ferr_i;
    push_flg_w[FLG_BI] = push_brk_i;
  end
  assign wdata_w = {push_flg_w, push_data_i};

  rxf_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_w),
    .wr_i    (wr_w),
    .pop_i   (pop_w),
    .wdata_i (wdata_w),
    .head_o  (head_w),
    .cnt_o   (cnt_w)
  );

  rxf_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_w),
    .pop_i      (pop_w),
    .lsr_rd_i   (lsr_rd_w),
    .ovr_evt_i  (ovr_evt_w),
    .nonempty_i (nonempty_w),
    .head_flg_i (head_w[ENT_W-1:DATA_W]),
    .flg_o      (flg_w),
    .ovr_o      (ovr_o),
    .irq_o      (irq_o)
  );

  always_comb begin
    lsr_w         = '0;
    lsr_w[LSR_DR] = nonempty_w;
    lsr_w[LSR_OE] = ovr_o;
    lsr_w[LSR_PE] = flg_w[FLG_PE];
    lsr_w[LSR_FE] = flg_w[FLG_FE];
    lsr_w[LSR_BI] = flg_w[FLG_BI];
  end

  assign dr_o      = nonempty_w;
  assign rd_data_o = reg_sel_i ? lsr_w : (nonempty_w ? head_w[DATA_W-1:0] : '0);
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              rd_i,
  input logic              reg_sel_i,
  input logic              flush_w,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              dr_o,
  input logic              ovr_o,
  input logic              irq_o
);
  // R1 / R5: an unflushed push always leaves a character behind
  a_r5_push_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !flush_w |=> dr_o);

  // R1: empty buffer reads as zero
  a_r1_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dr_o && !reg_sel_i |-> rd_data_o == '0);

  // R5: push with a buffer read never raises a fresh overrun
  a_r5_no_false_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && rd_i && !reg_sel_i && !ovr_o |=> !ovr_o);

  // R7: overrun holds without a status read
  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !(rd_i && reg_sel_i) |=> ovr_o);

  // R7: status read with no push clears overrun
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && reg_sel_i && !push_i |=> !ovr_o);

  // R8: overrun always raises the interrupt
  a_r8_irq_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> irq_o);

  // R9 / R10: a flush empties the buffer
  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> !dr_o);
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push_i    (push_i),
  .rd_i      (rd_i),
  .reg_sel_i (reg_sel_i),
  .flush_w   (flush_w),
  .rd_data_o (rd_data_o),
  .dr_o      (dr_o),
  .ovr_o     (ovr_o),
  .irq_o     (irq_o)
);

// File: tb/sim_rx_err_fifo.sv
module sim_rx_err_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic push_i = 0, push_perr_i = 0, push_ferr_i = 0, push_brk_i = 0;
  logic [DW-1:0] push_data_i = '0;
  logic rd_i = 0, reg_sel_i = 0, fifo_en_i = 0, rx_clr_i = 0;
  logic [DW-1:0] rd_data_o;
  logic dr_o, ovr_o, irq_o;

  always #2 clk = ~clk;  // 250 MHz

  rx_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
    .push_perr_i(push_perr_i), .push_ferr_i(push_ferr_i), .push_brk_i(push_brk_i),
    .rd_i(rd_i), .reg_sel_i(reg_sel_i), .fifo_en_i(fifo_en_i), .rx_clr_i(rx_clr_i),
    .rd_data_o(rd_data_o), .dr_o(dr_o), .ovr_o(ovr_o), .irq_o(irq_o));

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R11";
  bit g_en = 0;

  // reference model
  logic [10:0] mq[$];
  bit m_hide = 0, m_ovr = 0, m_en_q = 0;

  task automatic model_step(input bit p, input logic [7:0] d, input logic [2:0] f,
                            input bit rd, input bit sel, input bit en, input bit clr);
    int sz;
    bit flush, pop, full, ev;
    sz = mq.size();
    flush = clr || (m_en_q && !en);
    ev = 0;
    if (flush) begin
      mq.delete();
      m_hide = 0;
    end else begin
      pop = rd && !sel && sz > 0;
      full = en ? (sz == DEPTH) : (sz >= 1);
      if (pop) begin
        void'(mq.pop_front());
        m_hide = 0;
      end else if (rd && sel && sz > 0) m_hide = 1;
      ev = p && full && !pop;
      if (p && !ev) mq.push_back({f, d});
    end
    if (rd && sel) m_ovr = 0;
    if (ev) m_ovr = 1;
    m_en_q = en;
  endtask

  task automatic cmp(input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [2:0] hf;
    logic [7:0] lsr, exp_rd;
    bit dr;
    dr = mq.size() > 0;
    hf = (dr && !m_hide) ? mq[0][10:8] : 3'b000;
    lsr = {3'b000, hf[2], hf[1], hf[0], m_ovr, dr};
    exp_rd = reg_sel_i ? lsr : (dr ? mq[0][7:0] : 8'h00);
    cmp("dr_o", {7'b0, dr_o}, {7'b0, dr});
    cmp("ovr_o", {7'b0, ovr_o}, {7'b0, m_ovr});
    cmp("irq_o", {7'b0, irq_o}, {7'b0, (|hf) | m_ovr});
    cmp("rd_data_o", rd_data_o, exp_rd);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input bit p, input logic [7:0] d, input logic [2:0] f,
                      input bit rd, input bit sel, input bit clr);
    push_i = p; push_data_i = d;
    push_perr_i = f[0]; push_ferr_i = f[1]; push_brk_i = f[2];
    rd_i = rd; reg_sel_i = sel; rx_clr_i = clr; fifo_en_i = g_en;
    @(posedge clk);
    model_step(p, d, f, rd, sel, g_en, clr);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f); tick(1, d, f, 0, 0, 0); endtask
  task automatic rbr();  tick(0, 0, 0, 1, 0, 0); endtask
  task automatic lsr();  tick(0, 0, 0, 1, 1, 0); endtask
  task automatic peek(); tick(0, 0, 0, 0, 1, 0); endtask
  task automatic idle(); tick(0, 0, 0, 0, 0, 0); endtask
  task automatic drain(); while (mq.size() > 0) rbr(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    cur_req = "R11"; check_outputs(); peek();

    g_en = 1;
    cur_req = "R1";
    push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
    rbr(); rbr(); rbr(); idle();

    cur_req = "R2";
    push(8'hA1, 3'b001); push(8'hA2, 3'b010); push(8'hA3, 3'b100); push(8'hA4, 3'b000);
    for (int i = 0; i < 4; i++) begin peek(); rbr(); end
    peek();

    cur_req = "R3";
    push(8'h51, 3'b011); push(8'h52, 3'b100);
    peek(); lsr(); peek(); rbr(); peek(); lsr(); peek(); rbr(); peek();

    cur_req = "R4";
    tick(1, 8'h64, 3'b101, 1, 1, 0); peek(); idle(); lsr(); peek(); rbr();

    cur_req = "R5";
    g_en = 0; idle();
    push(8'h71, 0); tick(1, 8'h72, 3'b010, 1, 0, 0); peek(); rbr(); peek();
    g_en = 1; idle();
    for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i), 0);
    tick(1, 8'h9F, 0, 1, 0, 0); peek(); drain(); peek();

    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) push(8'(8'hC0 + i), 3'(i));
    push(8'hEE, 3'b111); peek(); idle(); drain(); lsr(); peek();
    g_en = 0; idle();
    push(8'h31, 0); push(8'h32, 0); peek(); rbr(); lsr(); peek();

    cur_req = "R7";
    push(8'h41, 0); tick(1, 8'h42, 0, 1, 1, 0); peek(); idle(); lsr(); peek(); rbr();

    cur_req = "R9";
    g_en = 1; idle();
    push(8'h01, 3'b001); push(8'h02, 0); push(8'h03, 0);
    g_en = 0; idle(); peek();
    push(8'h05, 3'b100); g_en = 1; idle(); peek(); rbr(); peek();

    cur_req = "R10";
    push(8'h0A, 0); push(8'h0B, 0); tick(1, 8'h0C, 3'b001, 0, 0, 1); peek();
    g_en = 0; idle(); push(8'h0D, 0); push(8'h0E, 0);
    tick(0, 0, 0, 0, 0, 1); peek(); lsr(); peek();

    cur_req = "R8";
    g_en = 1; idle();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 999));
      if (r < 4) g_en = ~g_en;
      tick(($urandom_range(0, 99) < 55), 8'($urandom), 3'($urandom_range(0, 7) & ($urandom_range(0, 3) == 0 ? 7 : 0)),
           ($urandom_range(0, 99) < 40), ($urandom_range(0, 99) < 35), (r > 992));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule